// File: doc/BRIEF.md
# Four-bit stack-machine core

This block is a multicycle processor whose only working storage is an evaluation stack of four-bit entries. It fetches four-bit instruction parcels from a 256-word instruction memory and moves operands to and from a separate 256-word data memory. Both memories are outside the block and are read combinationally. An 8-bit program counter walks the instruction stream. An opcode that needs an address is followed by two more parcels, high nibble first. The ALU and shifter take their operands from the top of the stack and leave their result there.

Subroutine linkage uses the same stack. A call saves the 8-bit return address as two nibbles and a return takes them back. If an instruction would overflow or underflow the stack, it is cancelled as a whole and a sticky error flag is raised. The pointer is kept as a signed value: -1 means empty, and it always names the current top entry.

Top module: `stk4_core`

## Requirements
- R1: After reset the stack pointer output reads -1 (all ones), the fetch address is 0, the error flag is 0 and the top-of-stack output reads 0.
- R2: A push first increments the pointer and then writes at the new top. A pop removes the top and then decrements the pointer. The top-of-stack output always shows the entry that the pointer names.
- R3: Opcodes 0000 ADD, 0001 SUB, 0010 AND and 0011 OR pop two entries and push one result, modulo 16. SUB computes second-from-top minus top.
- R4: Opcodes 0100 COMP (bitwise invert), 0101 INCR (plus one, modulo 16), 0110 rotate right by one and 0111 arithmetic shift right by one replace the top entry in place.
- R5: Opcode 1000, followed by the high and then the low address nibble, pushes the data-memory word at that address.
- R6: Opcode 1001, followed by two address nibbles, writes the top entry to that data-memory address in a single cycle and pops it.
- R7: Opcode 1010, followed by two address nibbles, loads the program counter with that 8-bit target.
- R8: Opcode 1011 branches when the top entry is 0, and opcode 1100 branches when its bit 3 is 1. Neither removes the top entry. When the condition is false, execution continues after the third parcel.
- R9: Opcode 1101 pushes the return address, low nibble first and then high nibble, and jumps. Opcode 1110 pops the high nibble and then the low nibble into the program counter.
- R10: An instruction that lacks the entries it pops (two for binary operations and return, one for unary, store and conditional branch), or the free slots it pushes (one for load, two for call), changes no stack entry, pointer, memory word or program-counter target. It sets an error flag that stays at 1 until reset. The pointer never exceeds depth minus one.
- R11: Opcode 1111 changes nothing and is one parcel long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 8 | Instruction memory address (program counter) |
| imem_data | input | 4 | Instruction parcel at imem_addr |
| dmem_addr | output | 8 | Data memory address |
| dmem_rdata | input | 4 | Data word at dmem_addr |
| dmem_wdata | output | 4 | Data to write (top of stack) |
| dmem_we | output | 1 | Data memory write enable |
| sp_o | output | 5 | Stack pointer, two's complement, -1 when empty |
| tos_o | output | 4 | Top-of-stack entry, 0 when empty |
| err_o | output | 1 | Sticky stack fault flag |

## Verification
The bench builds the core with its default four-bit word and a depth of sixteen. The narrow word makes it possible to try every operand pair for each binary operation, every value for each unary operation, and every top value for both conditional branches. A depth of sixteen lets an endless push loop reach overflow within a few hundred cycles. Call and return are run with subroutines placed at eight different targets, which checks both the nibble order and the address that control resumes at.

// File: rtl/stk4_pkg.sv
`timescale 1ns/1ps
package stk4_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0, OP_SUB, OP_AND, OP_OR,
        OP_COMP, OP_INCR, OP_RSR, OP_ASR,
        OP_PSHM, OP_POPM, OP_BR, OP_BRZ,
        OP_BRN, OP_JSR, OP_RTS, OP_NOP
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_AHI, ST_ALO, ST_EXEC, ST_JSR2, ST_RTS2
    } state_e;

    typedef enum logic [2:0] {
        SK_IDLE, SK_PUSH, SK_POP, SK_REPL, SK_MERGE
    } stkop_e;

endpackage

// File: rtl/stk4_alu.sv
`timescale 1ns/1ps
module stk4_alu
    import stk4_pkg::*;
#(
    parameter int DW = 4
) (
    input  opcode_e         op,
    input  logic [DW-1:0]   a,     // second from top
    input  logic [DW-1:0]   b,     // top
    output logic [DW-1:0]   y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_COMP: y = ~b;
            OP_INCR: y = b + DW'(1);
            OP_RSR:  y = {b[0], b[DW-1:1]};
            OP_ASR:  y = {b[DW-1], b[DW-1:1]};
            default: y = b;
        endcase
    end
endmodule

// File: rtl/stk4_stack.sv
`timescale 1ns/1ps
module stk4_stack
    import stk4_pkg::*;
#(
    parameter int DW    = 4,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  stkop_e                      op,
    input  logic [DW-1:0]               wdata,
    output logic [$clog2(DEPTH):0]      sp,
    output logic [$clog2(DEPTH):0]      fill,
    output logic [DW-1:0]               top,
    output logic [DW-1:0]               second
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            sp;
    } stk_t;

    stk_t q, d;
    logic [IW-1:0] idx_top, idx_up, idx_dn;
    logic          empty;

    always_comb begin
        d       = q;
        idx_top = q.sp[IW-1:0];
        idx_up  = idx_top + IW'(1);
        idx_dn  = idx_top - IW'(1);
        empty   = q.sp[PW-1];
        case (op)
            SK_PUSH: begin
                d.sp          = q.sp + PW'(1);
                d.mem[idx_up] = wdata;
            end
            SK_POP:   d.sp = q.sp - PW'(1);
            SK_REPL:  d.mem[idx_top] = wdata;
            SK_MERGE: begin
                d.mem[idx_dn] = wdata;
                d.sp          = q.sp - PW'(1);
            end
            default: ;
        endcase
        sp     = q.sp;
        fill   = q.sp + PW'(1);
        top    = empty ? '0 : q.mem[idx_top];
        second = q.mem[idx_dn];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mem <= '0;
            q.sp  <= '1;
        end else begin
            q <= d;
        end
    end

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(DEPTH)); // R10
    AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == SK_PUSH) |=> (top == $past(wdata))); // R2
endmodule

// File: rtl/stk4_core.sv
`timescale 1ns/1ps
module stk4_core
    import stk4_pkg::*;
#(
    parameter int DW    = 4,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [2*DW-1:0]          imem_addr,
    input  logic [DW-1:0]            imem_data,
    output logic [2*DW-1:0]          dmem_addr,
    input  logic [DW-1:0]            dmem_rdata,
    output logic [DW-1:0]            dmem_wdata,
    output logic                     dmem_we,
    output logic [$clog2(DEPTH):0]   sp_o,
    output logic [DW-1:0]            tos_o,
    output logic                     err_o
);
    localparam int AW = 2 * DW;
    localparam int PW = $clog2(DEPTH) + 1;

    typedef struct packed {
        state_e        st;
        opcode_e       ir;
        logic [AW-1:0] pc;
        logic [AW-1:0] tgt;
        logic [DW-1:0] hold;
        logic          err;
    } regs_t;

    localparam regs_t RST = '{st: ST_FETCH, ir: OP_NOP, pc: '0, tgt: '0, hold: '0, err: 1'b0};

    regs_t         q, d;
    stkop_e        sk_op;
    logic [DW-1:0] sk_wdata, top, second, alu_y;
    logic [PW-1:0] sp, fill;
    logic          fault;
    opcode_e       op_f;

    stk4_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .op(sk_op), .wdata(sk_wdata),
        .sp(sp), .fill(fill), .top(top), .second(second)
    );

    stk4_alu #(.DW(DW)) u_alu (
        .op(q.ir), .a(second), .b(top), .y(alu_y)
    );

    always_comb begin
        d        = q;
        sk_op    = SK_IDLE;
        sk_wdata = '0;
        dmem_we  = 1'b0;
        fault    = 1'b0;
        op_f     = opcode_e'(imem_data[3:0]);
        case (q.st)
            ST_FETCH: begin
                d.ir = op_f;
                d.pc = q.pc + AW'(1);
                d.st = (op_f >= OP_PSHM && op_f <= OP_JSR) ? ST_AHI : ST_EXEC;
            end
            ST_AHI: begin
                d.tgt[AW-1:DW] = imem_data;
                d.pc = q.pc + AW'(1);
                d.st = ST_ALO;
            end
            ST_ALO: begin
                d.tgt[DW-1:0] = imem_data;
                d.pc = q.pc + AW'(1);
                d.st = ST_EXEC;
            end
            ST_EXEC: begin
                d.st = ST_FETCH;
                case (q.ir)
                    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_RTS: fault = fill < PW'(2);
                    OP_COMP, OP_INCR, OP_RSR, OP_ASR,
                    OP_POPM, OP_BRZ, OP_BRN:               fault = fill == '0;
                    OP_PSHM:                               fault = fill == PW'(DEPTH);
                    OP_JSR:                                fault = fill > PW'(DEPTH - 2);
                    default:                               fault = 1'b0;
                endcase
                if (fault) begin
                    d.err = 1'b1;
                end else begin
                    case (q.ir)
                        OP_ADD, OP_SUB, OP_AND, OP_OR: begin
                            sk_op = SK_MERGE; sk_wdata = alu_y;
                        end
                        OP_COMP, OP_INCR, OP_RSR, OP_ASR: begin
                            sk_op = SK_REPL; sk_wdata = alu_y;
                        end
                        OP_PSHM: begin
                            sk_op = SK_PUSH; sk_wdata = dmem_rdata;
                        end
                        OP_POPM: begin
                            sk_op = SK_POP; dmem_we = 1'b1;
                        end
                        OP_BR:  d.pc = q.tgt;
                        OP_BRZ: if (top == '0) d.pc = q.tgt;
                        OP_BRN: if (top[DW-1]) d.pc = q.tgt;
                        OP_JSR: begin
                            sk_op = SK_PUSH; sk_wdata = q.pc[DW-1:0];
                            d.st  = ST_JSR2;
                        end
                        OP_RTS: begin
                            sk_op  = SK_POP; d.hold = top;
                            d.st   = ST_RTS2;
                        end
                        default: ;
                    endcase
                end
            end
            ST_JSR2: begin
                sk_op    = SK_PUSH;
                sk_wdata = q.pc[AW-1:DW];
                d.pc     = q.tgt;
                d.st     = ST_FETCH;
            end
            ST_RTS2: begin
                sk_op = SK_POP;
                d.pc  = {q.hold, top};
                d.st  = ST_FETCH;
            end
            default: d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign imem_addr  = q.pc;
    assign dmem_addr  = q.tgt;
    assign dmem_wdata = top;
    assign sp_o       = sp;
    assign tos_o      = top;
    assign err_o      = q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10
    AST_STORE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (fill == $past(fill) - PW'(1))); // R6
    AST_BRANCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && (q.ir == OP_BRZ || q.ir == OP_BRN)) |=> $stable(fill)); // R8
    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && fault) |=> (fill == $past(fill) && !$past(dmem_we))); // R10
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_AHI) |=> (imem_addr == $past(imem_addr) + AW'(1))); // R5
endmodule

// File: tb/sim_stk4_core.sv
`timescale 1ns/1ps
module sim_stk4_core;
    localparam int DW = 4;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] imem_addr, dmem_addr;
    logic [3:0] imem_data, dmem_rdata, dmem_wdata, tos_o;
    logic       dmem_we, err_o;
    logic [4:0] sp_o;

    logic [3:0] imem [256];
    logic [3:0] dmem [256];
    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    stk4_core #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .sp_o(sp_o), .tos_o(tos_o), .err_o(err_o)
    );

    task automatic tick();
        logic       w;
        logic [7:0] a;
        logic [3:0] v;
        w = dmem_we; a = dmem_addr; v = dmem_wdata;
        @(posedge clk);
        if (w) dmem[a] = v;
        @(negedge clk);
    endtask

    task automatic run(int n);
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        repeat (n) tick();
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 4'hF;
            dmem[i] = 4'h0;
        end
    endtask

    task automatic put3(int at, logic [3:0] op, logic [7:0] ad);
        imem[at]     = op;
        imem[at + 1] = ad[7:4];
        imem[at + 2] = ad[3:0];
    endtask

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bin_ref(int op, int a, int b);
        int r;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            default: r = a | b;
        endcase
        return r & 15;
    endfunction

    function automatic int un_ref(int op, int b);
        case (op)
            4: return (~b) & 15;
            5: return (b + 1) & 15;
            6: return ((b & 1) << 3) | (b >> 1);
            default: return (b & 8) | (b >> 1);
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        clear_mem();
        rst_n = 1'b0;
        tick(); tick();
        check("R1 sp", sp_o, 31);
        check("R1 err", err_o, 0);
        check("R1 pc", imem_addr, 0);
        check("R1 tos", tos_o, 0);

        // R2: two pushes
        for (int v = 0; v < 16; v++) begin
            clear_mem();
            dmem[0] = v[3:0]; dmem[1] = v[3:0] ^ 4'h5;
            put3(0, 4'h8, 8'h00); put3(3, 4'h8, 8'h01); put3(6, 4'hA, 8'h06);
            run(30);
            check("R2 sp", sp_o, 1);
            check("R2 tos", tos_o, (v ^ 5));
        end

        // R3 R5 R6: every operand pair for each binary op
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    clear_mem();
                    dmem[0] = a[3:0]; dmem[1] = b[3:0];
                    put3(0, 4'h8, 8'h00); put3(3, 4'h8, 8'h01);
                    imem[6] = op[3:0];
                    put3(7, 4'h9, 8'h02); put3(10, 4'hA, 8'h0A);
                    run(30);
                    check("R3 result", dmem[2], bin_ref(op, a, b));
                    if (a == 0 && b == 0) check("R6 sp after store", sp_o, 31);
                end

        // R4: every value for each unary op
        for (int op = 4; op < 8; op++)
            for (int b = 0; b < 16; b++) begin
                clear_mem();
                dmem[0] = b[3:0];
                put3(0, 4'h8, 8'h00); imem[3] = op[3:0];
                put3(4, 4'h9, 8'h02); put3(7, 4'hA, 8'h07);
                run(30);
                check("R4 result", dmem[2], un_ref(op, b));
                check("R4 sp", sp_o, 31);
            end

        // R7: unconditional branch skips fall-through
        clear_mem();
        dmem[0] = 4'd7; dmem[1] = 4'd2;
        put3(0, 4'hA, 8'h80); put3(3, 4'h8, 8'h01); put3(6, 4'hA, 8'h06);
        put3(8'h80, 4'h8, 8'h00); put3(8'h83, 4'hA, 8'h83);
        run(30);
        check("R7 tos", tos_o, 7);
        check("R7 sp", sp_o, 0);

        // R8: conditional branches on every top value
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 16; v++) begin
                bit taken;
                clear_mem();
                taken = (c == 0) ? (v == 0) : (v >= 8);
                dmem[0] = v[3:0];
                dmem[3] = 4'((v + 7) & 15); dmem[4] = 4'((v + 7) & 15);
                put3(0, 4'h8, 8'h00);
                put3(3, (c == 0) ? 4'hB : 4'hC, 8'h10);
                put3(6, 4'h9, 8'h03); put3(9, 4'hA, 8'h09);
                put3(8'h10, 4'h9, 8'h04); put3(8'h13, 4'hA, 8'h13);
                run(30);
                check("R8 taken path", dmem[taken ? 4 : 3], v);
                check("R8 other path", dmem[taken ? 3 : 4], (v + 7) & 15);
                check("R8 err", err_o, 0);
            end

        // R9: call/return and saved nibble order
        for (int k = 8; k < 16; k++) begin
            int t;
            t = k * 16 + (k % 3);
            clear_mem();
            dmem[6] = 4'd9;
            put3(0, 4'hA, 8'h40); put3(8'h40, 4'hD, 8'(t));
            put3(t, 4'h8, 8'h06); put3(t + 3, 4'h9, 8'h07); imem[t + 6] = 4'hE;
            put3(8'h43, 4'h8, 8'h06); put3(8'h46, 4'h9, 8'h0A); put3(8'h49, 4'hA, 8'h49);
            run(60);
            check("R9 subroutine ran", dmem[7], 9);
            check("R9 returned", dmem[10], 9);
            check("R9 sp", sp_o, 31);
            check("R9 err", err_o, 0);

            clear_mem();
            put3(0, 4'hA, 8'h40); put3(8'h40, 4'hD, 8'(t));
            put3(t, 4'h9, 8'h08); put3(t + 3, 4'h9, 8'h09); put3(t + 6, 4'hA, 8'(t + 6));
            run(50);
            check("R9 high nibble on top", dmem[8], 4);
            check("R9 low nibble below", dmem[9], 3);
        end

        // R10: overflow by endless pushes
        clear_mem();
        dmem[0] = 4'd11;
        put3(0, 4'h8, 8'h00); put3(3, 4'hA, 8'h00);
        run(200);
        check("R10 overflow sp", sp_o, 15);
        check("R10 overflow err", err_o, 1);
        check("R10 overflow tos", tos_o, 11);

        // R10: underflow on binary op and store
        clear_mem();
        dmem[2] = 4'd6;
        imem[0] = 4'h0; put3(1, 4'h9, 8'h02); put3(4, 4'hA, 8'h04);
        run(30);
        check("R10 underflow no write", dmem[2], 6);
        check("R10 underflow err", err_o, 1);
        check("R10 underflow sp", sp_o, 31);

        // R10: return on empty stack keeps pc flow
        clear_mem();
        dmem[0] = 4'd5;
        imem[0] = 4'hE; put3(1, 4'h8, 8'h00); put3(4, 4'hA, 8'h04);
        run(30);
        check("R10 rts fault err", err_o, 1);
        check("R10 rts fault continues", tos_o, 5);

        // R11: no-op parcels
        for (int v = 0; v < 16; v++) begin
            clear_mem();
            dmem[0] = v[3:0];
            put3(0, 4'h8, 8'h00); put3(6, 4'h9, 8'h02); put3(9, 4'hA, 8'h09);
            run(30);
            check("R11 value kept", dmem[2], v);
            check("R11 sp", sp_o, 31);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule